// File: doc/BRIEF.md
# I2C Target with Banked Word Memory

This block is a serial-bus target that sits in front of a small memory made of 16-bit words. The memory has a data area split into four banks and a separate lock area. The block watches the clock and data wires through a synchroniser clocked by a faster system clock. It detects start and stop conditions and checks the select byte against a fixed type nibble plus a 3-bit device address held in a loadable register. After a match it either takes a two-byte byte address and writes the bytes that follow, or it returns stored bytes from the current address pointer.

The two-byte address is split into fields. One bit picks the data area or the lock area, two bits pick a bank, a word index follows, and the lowest bit picks the upper or lower byte of the word. The pointer advances by one byte after every byte written or sent. It stays valid after a stop, so a controller can set the address in one transaction and read from it in a later one, or after a repeated start. The data output is an open-drain enable. When it is low the line is pulled low; when it is high the line is released.

Top module: `i2c_wordmem_target`

## Requirements
- R1: Both bus inputs pass through a synchroniser. If SDA falls while SCL is high, that is a START, and it re-arms the block to expect a select byte at any point in a transaction. If SDA rises while SCL is high, that is a STOP: the block releases SDA and goes idle.
- R2: A select byte whose bits 7..4 are 1010 and whose bits 3..1 equal the device address register matches. On a match, the block pulls SDA low during the ninth SCL pulse. Bit 0 of the select byte is the direction: 0 = write, 1 = read.
- R3: The device address register resets to 3'b011. It loads `cfg_dev_addr` in any cycle where `cfg_load` is 1, and holds its value otherwise.
- R4: If the select byte does not match, the block gives no acknowledge. Until the next START it acknowledges nothing and writes nothing.
- R5: In a write, the next two bytes form the 16-bit pointer, high byte first, and both are acknowledged. The fields are:
  - bit 15: area, 0 = data, 1 = lock.
  - bits 14..13: bank.
  - bits WORD_BITS..1: word index. Address bits above WORD_BITS and below 13 are ignored.
  - bit 0: byte half.
- R6: In a write, every byte after the pointer is acknowledged and stored at the pointer. The pointer then adds one to bits 12..0, wrapping from 13'h1FFF to 0. Bits 15..13 are left unchanged.
- R7: In a read, the block sends the byte at the pointer MSB first and then advances the pointer as in R6. It continues while the controller acknowledges. After a not-acknowledge it leaves SDA released.
- R8: The block changes its SDA drive only while SCL is low.
- R9: The pointer keeps its value across STOP and START.
- R10: After reset every memory byte reads 0 and the pointer is 0. The lock area and the data area are separate storage, even at the same word index.
- R11: `sda_oe_n` is 1 (released) in reset and whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe_n | output | 1 | Open-drain enable, 0 pulls SDA low |
| cfg_load | input | 1 | Loads the device address register |
| cfg_dev_addr | input | 3 | New 3-bit device address |

## Verification
The main test drives random burst writes and reads to random addresses in random areas and banks. These are compared against a byte model indexed by the address fields. This catches wrong field decode, wrong byte order and a wrong pointer step.

Directed sequences cover the remaining cases:
- Writing the same word index in both areas separates shared storage from split storage.
- A write that crosses 13'h1FFF exposes how the pointer wraps.
- A select byte with the wrong type, and one with the wrong device bits, each followed by data bytes, shows whether a non-selected target stays quiet and leaves memory untouched.
- Loading a new device address and issuing a start in the middle of a transaction check the re-addressing paths.

// File: rtl/i2c_wm_pkg.sv
// Shared types and constants for the I2C word-memory target.
package i2c_wm_pkg;

    // Protocol engine states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_END,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } eng_state_t;

    // Which byte of a write transaction is being received.
    typedef enum logic [1:0] {
        SG_SEL,
        SG_AHI,
        SG_ALO,
        SG_DATA
    } stage_t;

    localparam logic [3:0] TYPE_ID      = 4'b1010;
    localparam logic [2:0] DEV_ADDR_RST = 3'b011;
    localparam int         BANK_W       = 2;
    localparam int         PTR_W        = 16;

endpackage

// File: rtl/i2c_wm_sync.sv
// Multi-flop synchroniser with edge detection for asynchronous bus lines.
// Assumes idle-high lines: all flops reset to 1 so no edges appear at reset.
module i2c_wm_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    for (genvar ch = 0; ch < N; ch++) begin : g_ch
        logic [STAGES-1:0] pipe_q;
        logic              prev_q;

        // Shift the raw input through the synchroniser and keep one older copy.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe_q <= '1;
                prev_q <= 1'b1;
            end else begin
                pipe_q <= {pipe_q[STAGES-2:0], async_i[ch]};
                prev_q <= pipe_q[STAGES-1];
            end
        end

        assign level_o[ch] = pipe_q[STAGES-1];
        assign rise_o[ch]  = pipe_q[STAGES-1] & ~prev_q;
        assign fall_o[ch]  = ~pipe_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/i2c_wm_engine.sv
// Byte-level protocol engine. It receives the select byte, the pointer bytes
// and write data; it transmits read data and handles both acknowledge
// directions. Inputs are already synchronised levels and single-cycle edges.
// Assumes the system clock samples several times per SCL half period.
module i2c_wm_engine
    import i2c_wm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_lvl,
    input  logic             sda_rise,
    input  logic             sda_fall,
    input  logic [2:0]       dev_addr,
    input  logic [7:0]       mem_rdata,
    output logic             mem_wr_en,
    output logic [7:0]       mem_wdata,
    output logic [PTR_W-1:0] ptr_o,
    output logic             sda_low
);
    eng_state_t       state_q;
    stage_t           stage_q;
    logic [2:0]       cnt_q;
    logic [7:0]       rx_sh_q;
    logic [7:0]       tx_sh_q;
    logic [PTR_W-1:0] ptr_q;
    logic             go_tx_q;
    logic             more_q;
    logic             start_det;
    logic             stop_det;
    logic             sel_match;
    logic [PTR_W-1:0] ptr_next;

    // Bus conditions: an SDA edge while SCL stays high.
    assign start_det = scl_lvl & sda_fall;
    assign stop_det  = scl_lvl & sda_rise;

    // Select byte compare against type nibble and configured address.
    assign sel_match = (rx_sh_q[7:4] == TYPE_ID) && (rx_sh_q[3:1] == dev_addr);

    // Pointer step: bits 12..0 count and wrap, area and bank are kept.
    assign ptr_next = {ptr_q[15:13], ptr_q[12:0] + 13'd1};

    // A write strobe fires at the end of a received data byte.
    assign mem_wr_en = (state_q == ST_RX_END) && scl_fall && (stage_q == SG_DATA)
                       && !start_det && !stop_det;
    assign mem_wdata = rx_sh_q;
    assign ptr_o     = ptr_q;

    // Main protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            stage_q <= SG_SEL;
            cnt_q   <= '0;
            rx_sh_q <= '0;
            tx_sh_q <= '0;
            ptr_q   <= '0;
            go_tx_q <= 1'b0;
            more_q  <= 1'b0;
            sda_low <= 1'b0;
        end else if (start_det) begin
            state_q <= ST_RX;
            stage_q <= SG_SEL;
            cnt_q   <= '0;
            go_tx_q <= 1'b0;
            sda_low <= 1'b0;
        end else if (stop_det) begin
            state_q <= ST_IDLE;
            sda_low <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    sda_low <= 1'b0;
                end
                ST_RX: begin
                    if (scl_rise) begin
                        rx_sh_q <= {rx_sh_q[6:0], sda_lvl};
                        cnt_q   <= cnt_q + 3'd1;
                        if (cnt_q == 3'd7) state_q <= ST_RX_END;
                    end
                end
                ST_RX_END: begin
                    if (scl_fall) begin
                        state_q <= ST_RX_ACK;
                        sda_low <= 1'b1;
                        unique case (stage_q)
                            SG_SEL: begin
                                if (sel_match) begin
                                    go_tx_q <= rx_sh_q[0];
                                    stage_q <= rx_sh_q[0] ? SG_DATA : SG_AHI;
                                end else begin
                                    state_q <= ST_IDLE;
                                    sda_low <= 1'b0;
                                end
                            end
                            SG_AHI: begin
                                ptr_q[15:8] <= rx_sh_q;
                                stage_q     <= SG_ALO;
                            end
                            SG_ALO: begin
                                ptr_q[7:0] <= rx_sh_q;
                                stage_q    <= SG_DATA;
                            end
                            SG_DATA: begin
                                ptr_q <= ptr_next;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        cnt_q <= '0;
                        if (go_tx_q) begin
                            tx_sh_q <= mem_rdata;
                            sda_low <= ~mem_rdata[7];
                            state_q <= ST_TX;
                        end else begin
                            sda_low <= 1'b0;
                            state_q <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cnt_q == 3'd7) begin
                            sda_low <= 1'b0;
                            cnt_q   <= '0;
                            ptr_q   <= ptr_next;
                            state_q <= ST_TX_ACK;
                        end else begin
                            tx_sh_q <= {tx_sh_q[6:0], 1'b0};
                            sda_low <= ~tx_sh_q[6];
                            cnt_q   <= cnt_q + 3'd1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) more_q <= ~sda_lvl;
                    if (scl_fall) begin
                        if (more_q) begin
                            tx_sh_q <= mem_rdata;
                            sda_low <= ~mem_rdata[7];
                            state_q <= ST_TX;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1: a START re-arms reception of a select byte with SDA released.
    a_r1_start_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_RX && stage_q == SG_SEL && cnt_q == 3'd0 && !sda_low));

    // R1: a STOP returns the engine to idle.
    a_r1_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE && !sda_low));

    // R4: a non-matching select byte leads to idle with no acknowledge.
    a_r4_mismatch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RX_END && scl_fall && stage_q == SG_SEL && !sel_match
         && !start_det && !stop_det) |=> (state_q == ST_IDLE && !sda_low));

    // R6: each stored byte steps the pointer by one inside bits 12..0.
    a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> (ptr_q[12:0] == $past(ptr_q[12:0]) + 13'd1
                       && ptr_q[15:13] == $past(ptr_q[15:13])));

    // R8: the drive changes only in cycles following a low SCL sample.
    a_r8_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low) |-> !$past(scl_lvl));

    // R11: the line is never pulled while idle.
    a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_low);
endmodule

// File: rtl/i2c_wm_mem.sv
// Behavioural byte-addressed storage: a banked data area plus a lock area.
// Assumes one write per cycle; read is combinational from the field inputs.
module i2c_wm_mem
    import i2c_wm_pkg::*;
#(
    parameter int WORD_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 area_lock,
    input  logic [BANK_W-1:0]    bank,
    input  logic [WORD_BITS-1:0] word,
    input  logic                 half,
    input  logic                 wr_en,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata
);
    localparam int DIDX_W     = BANK_W + WORD_BITS + 1;
    localparam int LIDX_W     = WORD_BITS + 1;
    localparam int DATA_BYTES = 1 << DIDX_W;
    localparam int LOCK_BYTES = 1 << LIDX_W;

    logic [7:0]        data_q [DATA_BYTES];
    logic [7:0]        lock_q [LOCK_BYTES];
    logic [DIDX_W-1:0] didx;
    logic [LIDX_W-1:0] lidx;

    assign didx = {bank, word, half};
    assign lidx = {word, half};

    // Clear on reset, store the addressed byte on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DATA_BYTES; i++) data_q[i] <= '0;
            for (int i = 0; i < LOCK_BYTES; i++) lock_q[i] <= '0;
        end else if (wr_en) begin
            if (area_lock) lock_q[lidx] <= wdata;
            else           data_q[didx] <= wdata;
        end
    end

    // Return the byte the fields select.
    assign rdata = area_lock ? lock_q[lidx] : data_q[didx];
endmodule

// File: rtl/i2c_wordmem_target.sv
// Top level: synchroniser, device address register, protocol engine and memory.
// Assumes an external pull-up on SDA; sda_oe_n low means the pin is driven low.
module i2c_wordmem_target
    import i2c_wm_pkg::*;
#(
    parameter int WORD_BITS   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_n,
    input  logic       cfg_load,
    input  logic [2:0] cfg_dev_addr
);
    logic [1:0]       lvl, rise, fall;
    logic [2:0]       dev_addr_q;
    logic             wr_en;
    logic [7:0]       wdata, rdata;
    logic [PTR_W-1:0] ptr;
    logic             sda_low;
    logic             unused_word_hi;

    i2c_wm_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    // Device address register, loadable at run time.
    always_ff @(posedge clk) begin
        if (!rst_n)        dev_addr_q <= DEV_ADDR_RST;
        else if (cfg_load) dev_addr_q <= cfg_dev_addr;
    end

    i2c_wm_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (lvl[1]),
        .scl_rise  (rise[1]),
        .scl_fall  (fall[1]),
        .sda_lvl   (lvl[0]),
        .sda_rise  (rise[0]),
        .sda_fall  (fall[0]),
        .dev_addr  (dev_addr_q),
        .mem_rdata (rdata),
        .mem_wr_en (wr_en),
        .mem_wdata (wdata),
        .ptr_o     (ptr),
        .sda_low   (sda_low)
    );

    i2c_wm_mem #(.WORD_BITS(WORD_BITS)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .area_lock (ptr[15]),
        .bank      (ptr[14:13]),
        .word      (ptr[WORD_BITS:1]),
        .half      (ptr[0]),
        .wr_en     (wr_en),
        .wdata     (wdata),
        .rdata     (rdata)
    );

    assign unused_word_hi = ^ptr[12:WORD_BITS+1];
    assign sda_oe_n       = ~sda_low;

    // R3: the device address holds unless a load is requested.
    a_r3_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(dev_addr_q));
endmodule

// File: tb/i2c_wordmem_target_test.sv
module i2c_wordmem_target_test;
    localparam int WB         = 6;
    localparam int DATA_BYTES = 1 << (2 + WB + 1);
    localparam int LOCK_BYTES = 1 << (WB + 1);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       cfg_load = 1'b0;
    logic [2:0] cfg_dev_addr = 3'b000;
    logic       sda_oe_n;
    logic       sda_bus;

    int checks = 0;
    int fails  = 0;
    int r8_viol = 0;
    bit done = 1'b0;

    logic [7:0]  ref_data [DATA_BYTES];
    logic [7:0]  ref_lock [LOCK_BYTES];
    logic [15:0] ref_ptr;
    logic [2:0]  cur_dev;

    always #5 clk = ~clk;

    assign sda_bus = sda_m & sda_oe_n;

    i2c_wordmem_target #(.WORD_BITS(WB)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .sda_oe_n     (sda_oe_n),
        .cfg_load     (cfg_load),
        .cfg_dev_addr (cfg_dev_addr)
    );

    // R8 monitor: the target's drive must not change while SCL is high.
    logic prev_oe = 1'b1;
    always @(posedge clk) begin
        if (rst_n && sda_oe_n !== prev_oe && scl_m) r8_viol++;
        prev_oe <= sda_oe_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] next_ptr(input logic [15:0] a);
        return {a[15:13], a[12:0] + 13'd1};
    endfunction

    function automatic logic [7:0] ref_get(input logic [15:0] a);
        if (a[15]) return ref_lock[{a[WB:1], a[0]}];
        return ref_data[{a[14:13], a[WB:1], a[0]}];
    endfunction

    task automatic ref_put(input logic [15:0] a, input logic [7:0] v);
        if (a[15]) ref_lock[{a[WB:1], a[0]}] = v;
        else       ref_data[{a[14:13], a[WB:1], a[0]}] = v;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input bit d, output bit s);
        wait_cyc(8);  sda_m = d;
        wait_cyc(12); scl_m = 1'b1;
        wait_cyc(10); s = sda_bus;
        wait_cyc(10); scl_m = 1'b0;
    endtask

    task automatic bus_start();
        if (!scl_m) begin
            wait_cyc(8);  sda_m = 1'b1;
            wait_cyc(12); scl_m = 1'b1;
            wait_cyc(10);
        end
        sda_m = 1'b0;
        wait_cyc(10); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_cyc(8);  sda_m = 1'b0;
        wait_cyc(12); scl_m = 1'b1;
        wait_cyc(10); sda_m = 1'b1;
        wait_cyc(20);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] v);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(!give_ack, s);
    endtask

    // Open a write transaction and load the pointer (R5); no stop.
    task automatic set_ptr(input logic [15:0] a);
        bit ack;
        bus_start();
        send_byte({4'b1010, cur_dev, 1'b0}, ack);
        chk(ack, "R2 select ack", ack, 1);
        send_byte(a[15:8], ack);
        chk(ack, "R5 high ptr ack", ack, 1);
        send_byte(a[7:0], ack);
        chk(ack, "R5 low ptr ack", ack, 1);
        ref_ptr = a;
    endtask

    task automatic write_burst(input logic [15:0] a, input int n);
        bit ack;
        logic [7:0] v;
        set_ptr(a);
        for (int k = 0; k < n; k++) begin
            v = 8'($urandom);
            send_byte(v, ack);
            chk(ack, "R6 data ack", ack, 1);
            ref_put(ref_ptr, v);
            ref_ptr = next_ptr(ref_ptr);
        end
        bus_stop();
    endtask

    // Read n bytes from the current pointer after a (repeated) start (R7, R9).
    task automatic read_here(input int n, input string req);
        bit ack;
        bit s;
        logic [7:0] v;
        logic [7:0] e;
        bus_start();
        send_byte({4'b1010, cur_dev, 1'b1}, ack);
        chk(ack, "R2 read select ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            e = ref_get(ref_ptr);
            recv_byte(k < n - 1, v);
            chk(v == e, req, v, e);
            ref_ptr = next_ptr(ref_ptr);
        end
        clk_bit(1'b1, s);
        chk(s == 1'b1, "R7 released after nack", s, 1);
        bus_stop();
    endtask

    task automatic read_burst(input logic [15:0] a, input int n, input string req);
        set_ptr(a);
        read_here(n, req);
    endtask

    initial begin
        bit ack;
        logic [15:0] a;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < DATA_BYTES; i++) ref_data[i] = '0;
        for (int i = 0; i < LOCK_BYTES; i++) ref_lock[i] = '0;
        ref_ptr = '0;
        cur_dev = 3'b011;

        wait_cyc(5);
        chk(sda_oe_n == 1'b1, "R11 released in reset", sda_oe_n, 1);
        rst_n = 1'b1;
        wait_cyc(5);
        chk(sda_oe_n == 1'b1, "R11 released idle", sda_oe_n, 1);

        // R10/R3: read at reset pointer with reset device address.
        read_here(2, "R10 reset content");

        // Basic write and read back in data area (R5, R6, R7).
        write_burst(16'h2024, 4);
        read_burst(16'h2024, 4, "R7 readback");

        // R9: pointer survives stop; read continues from where it was.
        read_burst(16'h2024, 2, "R9 first half");
        read_here(2, "R9 continued");

        // R10/R5: lock area is separate from data area at the same word.
        write_burst(16'h000A, 2);
        write_burst(16'h800A, 2);
        read_burst(16'h000A, 2, "R10 data area");
        read_burst(16'h800A, 2, "R10 lock area");

        // R6: pointer wraps in bits 12..0 and keeps area and bank.
        write_burst(16'h5FFF, 2);
        read_burst(16'h4000, 1, "R6 wrap target");
        read_burst(16'h5FFF, 1, "R6 wrap origin");

        // R4: wrong type nibble, then data bytes, all ignored.
        bus_start();
        send_byte({4'b1011, cur_dev, 1'b0}, ack);
        chk(!ack, "R4 wrong type nack", ack, 0);
        send_byte(8'h20, ack);
        chk(!ack, "R4 ignored ptr byte", ack, 0);
        send_byte(8'h24, ack);
        send_byte(8'hC3, ack);
        chk(!ack, "R4 ignored data byte", ack, 0);
        chk(sda_oe_n == 1'b1, "R4 line released", sda_oe_n, 1);
        bus_stop();
        // R4: wrong device bits.
        bus_start();
        send_byte({4'b1010, 3'b100, 1'b0}, ack);
        chk(!ack, "R4 wrong device nack", ack, 0);
        bus_stop();
        read_burst(16'h2024, 2, "R4 memory untouched");

        // R1: START in the middle of a write re-arms select reception.
        bus_start();
        send_byte({4'b1010, cur_dev, 1'b0}, ack);
        send_byte(8'h01, ack);
        write_burst(16'h2030, 2);
        read_burst(16'h2030, 2, "R1 restart write");

        // Constrained random bursts across areas and banks.
        for (int it = 0; it < 14; it++) begin
            int n;
            a = 16'($urandom);
            n = 1 + int'($urandom_range(2));
            write_burst(a, n);
            read_burst(a, n, "R5 random fields");
        end

        // R3: new device address; old one stops matching.
        @(negedge clk);
        cfg_dev_addr = 3'b101;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_dev_addr = 3'b010;
        wait_cyc(3);
        bus_start();
        send_byte({4'b1010, 3'b011, 1'b0}, ack);
        chk(!ack, "R3 old address nack", ack, 0);
        bus_stop();
        cur_dev = 3'b101;
        write_burst(16'h6011, 2);
        read_burst(16'h6011, 2, "R3 new address");

        chk(r8_viol == 0, "R8 drive change with SCL high", r8_viol, 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule